// File: doc/BRIEF.md
# Reverse-Link Escape-Mode Packet Receiver

This block receives the traffic that a display peripheral sends back to the host after a bus turnaround, over the low-power escape interface of a serial display lane. It watches the escape clock, the received byte, the data-valid and low-power-data flags, a one-hot trigger vector, the lane stop state and the lane direction. All of these are asynchronous to the system clock. The block synchronizes the control lines and detects escape clock rising edges in the system clock domain. On such an edge it captures the byte.

Received bytes are grouped into packets. The first four bytes form a header. When checking is enabled, a 6-bit code in the header is used to correct a single flipped bit or to flag a multi-bit error. The corrected header gives a virtual channel, a data type and a 16-bit word. For a long packet the word is the payload length, and up to 16 payload bytes are kept in a buffer that software reads by index. Trigger codes are passed on as one-cycle pulses. Packet errors are collected quietly and copied into a status register all at once, at the instant the lane changes direction.

Top module: `rp_escape_rx`

## Requirements
- R1: While the synchronized lane direction `lane_dir` is low, no byte is captured and no trigger pulse is produced.
- R2: A byte is taken on a rising edge of `esc_clk` only when `esc_valid` and `esc_lpdt` are both high; `esc_data` bit 0 is the earliest bit on the wire, and a byte with `esc_lpdt` low is ignored.
- R3: The header is four bytes in arrival order. Byte 0 holds the virtual channel in bits 7:6 and the data type in bits 5:0. Bytes 1 and 2 hold the 16-bit word, low byte first. Byte 3 holds the check code in bits 5:0. When the header completes, `hdr_done` pulses and `hdr_vc`, `hdr_dtype` and `hdr_word` update. A data type with bit 3 set is a long packet; any other data type is a short packet with no payload.
- R4: Check code: data bit i (bytes 0 to 2, i = 0..23) has the i-th value in ascending order among 3..31 that is not a power of two. Code bits 4:0 are the XOR of the values of all set data bits. Code bit 5 makes the parity of all 30 bits even. With `ecc_en` high, a single flipped bit is corrected and error bit 0 is raised.
- R5: With `ecc_en` high, a header with more than one flipped bit raises error bit 1. The header outputs and the payload count keep their old values, and bytes are discarded until stop state. With `ecc_en` low, the header is used exactly as received and no check error is raised.
- R6: At most 16 payload bytes are stored, and a long packet whose word count is above 16 raises error bit 3. `rd_byte` returns the byte at `rd_idx` below `pay_cnt`, and 0 at or above it.
- R7: Stop state arriving in the middle of a header or a payload raises error bit 2 and ends the packet.
- R8: `err_status` changes only when the synchronized direction changes, on either edge, or on `rp_init`. A direction change copies all errors gathered since the previous change into `err_status`, with bit 0 corrected, bit 1 uncorrectable, bit 2 truncated and bit 3 oversize.
- R9: When any trigger bit rises, `trg_pulse` is high for exactly one cycle with `trg_code` equal to the one-hot trigger. `trg_te` is set for trigger bit 1 and `trg_ack` for trigger bit 2.
- R10: `rd_start` empties the payload buffer (`pay_cnt` becomes 0). `rp_init` returns the whole receive path, including `err_status`, to its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| esc_clk | input | 1 | Escape clock from the lane |
| esc_data | input | 8 | Received escape byte, bit 0 first on the wire |
| esc_valid | input | 1 | Received byte valid |
| esc_lpdt | input | 1 | Lane is in low-power data receive mode |
| esc_trig | input | 4 | One-hot received trigger |
| esc_stop | input | 1 | Lane stop state, asynchronous |
| lane_dir | input | 1 | Lane direction, high means receive |
| ecc_en | input | 1 | Enable header correction |
| rd_start | input | 1 | New read command, empties the payload buffer |
| rp_init | input | 1 | Re-initialize the receive path |
| rd_idx | input | 4 | Payload byte index for readout |
| rd_byte | output | 8 | Payload byte at `rd_idx` |
| pay_cnt | output | 5 | Number of stored payload bytes |
| hdr_done | output | 1 | One-cycle pulse at header completion |
| hdr_vc | output | 2 | Virtual channel of last accepted header |
| hdr_dtype | output | 6 | Data type of last accepted header |
| hdr_word | output | 16 | Word count or short data of last accepted header |
| trg_pulse | output | 1 | One-cycle trigger request |
| trg_code | output | 4 | Trigger value during the pulse |
| trg_te | output | 1 | Tearing-effect trigger flag during the pulse |
| trg_ack | output | 1 | No-error acknowledge flag during the pulse |
| err_status | output | 4 | Errors published at the last direction change |

## Verification
Some properties are checked on every cycle. No byte strobe follows a cycle in which the direction is low. The payload count never exceeds 16. The status register holds still unless the direction changes or an init occurs. A trigger pulse never lasts two cycles and always carries exactly one code bit. A header that cannot be corrected leaves the payload count and the header outputs untouched. Other behaviour can only be shown by the bench's scenarios: correct header and payload contents, the specific correction of a chosen flipped bit, the bypass when checking is off, truncation, the oversize drop, and the exact error word published at a turnaround.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int HDR_BYTES = 4;
  localparam int ERR_W = 4;
  localparam logic [ERR_W-1:0] ERR_CORR  = 4'b0001;
  localparam logic [ERR_W-1:0] ERR_UNC   = 4'b0010;
  localparam logic [ERR_W-1:0] ERR_TRUNC = 4'b0100;
  localparam logic [ERR_W-1:0] ERR_OVF   = 4'b1000;

  typedef enum logic [1:0] {ST_HDR, ST_PAY, ST_SKIP} rx_st_e;

  // i-th value among 3..31 that is not a power of two
  function automatic logic [4:0] ecc_code(input int idx);
    int n;
    logic [4:0] r;
    n = 0;
    r = '0;
    for (int v = 3; v < 32; v++) begin
      if ((v & (v - 1)) != 0) begin
        if (n == idx) r = v[4:0];
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [5:0] ecc_gen(input logic [23:0] d);
    logic [4:0] p;
    p = '0;
    for (int i = 0; i < 24; i++)
      if (d[i]) p = p ^ ecc_code(i);
    return {(^d) ^ (^p), p};
  endfunction
endpackage

// File: rtl/rp_sync.sv
module rp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rp_lane_capture.sv
module rp_lane_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       esc_clk,
  input  logic [7:0] esc_data,
  input  logic       esc_valid,
  input  logic       esc_lpdt,
  input  logic       rx_en,
  output logic       byte_stb,
  output logic [7:0] byte_q
);
  logic clk_s, clk_prev, clk_rise;

  rp_sync #(.W(1), .STAGES(SYNC_STAGES)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .d(esc_clk), .q(clk_s));

  assign clk_rise = clk_s & ~clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b0;
      byte_stb <= 1'b0;
      byte_q   <= '0;
    end else begin
      clk_prev <= clk_s;
      byte_stb <= clk_rise & esc_valid & esc_lpdt & rx_en;
      if (clk_rise) byte_q <= esc_data;
    end
  end

  // R1: no capture follows a cycle with reception disabled
  p_dir_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !byte_stb);
endmodule

// File: rtl/rp_hdr_ecc.sv
module rp_hdr_ecc (
  input  logic [29:0] hdr_in,
  input  logic        ecc_en,
  output logic [23:0] hdr_fix,
  output logic        corr,
  output logic        uncorr
);
  logic [23:0] data;
  logic [5:0]  recv;
  logic [5:0]  calc;
  logic [4:0]  syn;
  logic        odd;
  logic        hit;

  assign data = hdr_in[23:0];
  assign recv = hdr_in[29:24];
  assign calc = rp_pkg::ecc_gen(data);
  assign syn  = calc[4:0] ^ recv[4:0];
  assign odd  = (^data) ^ (^recv);

  always_comb begin
    hdr_fix = data;
    corr    = 1'b0;
    uncorr  = 1'b0;
    hit     = 1'b0;
    if (ecc_en) begin
      if (!odd) begin
        uncorr = (syn != 5'd0);
      end else if ((syn & (syn - 5'd1)) == 5'd0) begin
        corr = 1'b1;
      end else begin
        for (int i = 0; i < 24; i++) begin
          if (rp_pkg::ecc_code(i) == syn) begin
            hdr_fix[i] = ~data[i];
            hit = 1'b1;
          end
        end
        corr   = hit;
        uncorr = ~hit;
      end
    end
  end
endmodule

// File: rtl/rp_escape_rx.sv
module rp_escape_rx #(
  parameter int PAY_MAX     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       esc_clk,
  input  logic [7:0]                 esc_data,
  input  logic                       esc_valid,
  input  logic                       esc_lpdt,
  input  logic [3:0]                 esc_trig,
  input  logic                       esc_stop,
  input  logic                       lane_dir,
  input  logic                       ecc_en,
  input  logic                       rd_start,
  input  logic                       rp_init,
  input  logic [$clog2(PAY_MAX)-1:0] rd_idx,
  output logic [7:0]                 rd_byte,
  output logic [$clog2(PAY_MAX+1)-1:0] pay_cnt,
  output logic                       hdr_done,
  output logic [1:0]                 hdr_vc,
  output logic [5:0]                 hdr_dtype,
  output logic [15:0]                hdr_word,
  output logic                       trg_pulse,
  output logic [3:0]                 trg_code,
  output logic                       trg_te,
  output logic                       trg_ack,
  output logic [3:0]                 err_status
);
  import rp_pkg::*;

  localparam int CNT_W = $clog2(PAY_MAX + 1);
  localparam int IDX_W = $clog2(PAY_MAX);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAY_MAX);
  localparam logic [15:0] WC_MAX = 16'(PAY_MAX);

  // ---- synchronizers ----
  logic [5:0] ctl_s;
  logic       dir_s, stop_s, dir_q, stop_q, dir_chg, stop_rise;
  logic [3:0] trig_s;
  logic       trig_any, trig_prev, trig_rise;

  rp_sync #(.W(6), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({esc_trig, esc_stop, lane_dir}), .q(ctl_s));

  assign dir_s     = ctl_s[0];
  assign stop_s    = ctl_s[1];
  assign trig_s    = ctl_s[5:2];
  assign dir_chg   = dir_s ^ dir_q;
  assign stop_rise = stop_s & ~stop_q;
  assign trig_any  = (|trig_s) & dir_s;
  assign trig_rise = trig_any & ~trig_prev;

  // ---- byte capture ----
  logic       byte_stb;
  logic [7:0] byte_q;

  rp_lane_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .esc_clk(esc_clk), .esc_data(esc_data),
    .esc_valid(esc_valid), .esc_lpdt(esc_lpdt), .rx_en(dir_s),
    .byte_stb(byte_stb), .byte_q(byte_q));

  // ---- header check ----
  rx_st_e      st;
  logic [1:0]  hdr_cnt;
  logic [23:0] hdr_sh;
  logic [23:0] hdr_fix;
  logic        hdr_corr, hdr_unc;

  rp_hdr_ecc u_ecc (
    .hdr_in({byte_q[5:0], hdr_sh}), .ecc_en(ecc_en),
    .hdr_fix(hdr_fix), .corr(hdr_corr), .uncorr(hdr_unc));

  // ---- named events ----
  logic        hdr_full, is_long, trunc;
  logic [15:0] wc;
  logic [ERR_W-1:0] hdr_flags;

  assign hdr_full  = byte_stb && (st == ST_HDR) && (hdr_cnt == 2'd3);
  assign is_long   = hdr_fix[3];
  assign wc        = hdr_fix[23:8];
  assign trunc     = stop_rise && (((st == ST_HDR) && (hdr_cnt != 2'd0)) || (st == ST_PAY));
  assign hdr_flags = (hdr_corr ? ERR_CORR : '0) | ((is_long && (wc > WC_MAX)) ? ERR_OVF : '0);

  // ---- packet state ----
  logic [15:0]      rem;
  logic [ERR_W-1:0] pkt_err, pending;
  logic             pay_wr;

  assign pay_wr = byte_stb && (st == ST_PAY) && !dir_chg && !trunc && (pay_cnt < CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0; stop_q <= 1'b0; trig_prev <= 1'b0;
      trg_pulse <= 1'b0; trg_code <= '0; trg_te <= 1'b0; trg_ack <= 1'b0;
    end else begin
      dir_q     <= dir_s;
      stop_q    <= stop_s;
      trig_prev <= trig_any;
      trg_pulse <= trig_rise & ~rp_init;
      trg_code  <= (trig_rise & ~rp_init) ? trig_s : '0;
      trg_te    <= trig_rise & ~rp_init & trig_s[1];
      trg_ack   <= trig_rise & ~rp_init & trig_s[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_HDR; hdr_cnt <= '0; hdr_sh <= '0; rem <= '0;
      pkt_err <= '0; pending <= '0; err_status <= '0; pay_cnt <= '0;
      hdr_done <= 1'b0; hdr_vc <= '0; hdr_dtype <= '0; hdr_word <= '0;
    end else if (rp_init) begin
      st <= ST_HDR; hdr_cnt <= '0; hdr_sh <= '0; rem <= '0;
      pkt_err <= '0; pending <= '0; err_status <= '0; pay_cnt <= '0;
      hdr_done <= 1'b0; hdr_vc <= '0; hdr_dtype <= '0; hdr_word <= '0;
    end else begin
      hdr_done <= 1'b0;
      if (rd_start) pay_cnt <= '0;
      if (dir_chg) begin
        err_status <= pending | pkt_err;
        pending    <= '0;
        pkt_err    <= '0;
        st         <= ST_HDR;
        hdr_cnt    <= '0;
      end else if (trunc) begin
        pending <= pending | pkt_err | ERR_TRUNC;
        pkt_err <= '0;
        st      <= ST_HDR;
        hdr_cnt <= '0;
      end else if (stop_rise && (st == ST_SKIP)) begin
        st      <= ST_HDR;
        hdr_cnt <= '0;
      end else if (byte_stb) begin
        unique case (st)
          ST_HDR: begin
            hdr_cnt <= hdr_cnt + 2'd1;
            if (hdr_cnt != 2'd3) begin
              hdr_sh <= {byte_q, hdr_sh[23:8]};
            end else begin
              hdr_done <= 1'b1;
              if (hdr_unc) begin
                pending <= pending | pkt_err | ERR_UNC;
                pkt_err <= '0;
                st      <= ST_SKIP;
              end else begin
                hdr_vc    <= hdr_fix[7:6];
                hdr_dtype <= hdr_fix[5:0];
                hdr_word  <= wc;
                if (is_long) pay_cnt <= '0;
                if (is_long && (wc != 16'd0)) begin
                  st      <= ST_PAY;
                  rem     <= wc;
                  pkt_err <= pkt_err | hdr_flags;
                end else begin
                  pending <= pending | pkt_err | hdr_flags;
                  pkt_err <= '0;
                end
              end
            end
          end
          ST_PAY: begin
            if (pay_wr) pay_cnt <= pay_cnt + 1'b1;
            rem <= rem - 16'd1;
            if (rem == 16'd1) begin
              pending <= pending | pkt_err;
              pkt_err <= '0;
              st      <= ST_HDR;
              hdr_cnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---- payload buffer ----
  logic [7:0] pay_mem [PAY_MAX];

  always_ff @(posedge clk) begin
    if (pay_wr) pay_mem[pay_cnt[IDX_W-1:0]] <= byte_q;
  end

  assign rd_byte = (CNT_W'(rd_idx) < pay_cnt) ? pay_mem[rd_idx] : 8'h00;

  // ---- assertions ----
  p_pay_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pay_cnt <= CNT_MAX);

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_chg && !rp_init) |=> $stable(err_status));

  p_trig_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trg_pulse |=> !trg_pulse);

  p_trig_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trg_pulse |-> ($countones(trg_code) == 1));

  p_unc_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_full && hdr_unc && !dir_chg && !trunc && !rd_start && !rp_init)
      |=> ($stable(pay_cnt) && $stable(hdr_vc) && $stable(hdr_word)));
endmodule

// File: tb/rp_escape_rx_tb.sv
module rp_escape_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;
  localparam logic [4:0] CODES [24] = '{5'd3, 5'd5, 5'd6, 5'd7, 5'd9, 5'd10,
    5'd11, 5'd12, 5'd13, 5'd14, 5'd15, 5'd17, 5'd18, 5'd19, 5'd20, 5'd21,
    5'd22, 5'd23, 5'd24, 5'd25, 5'd26, 5'd27, 5'd28, 5'd29};

  typedef struct packed { logic [1:0] vc; logic [5:0] dt; logic [15:0] word; } hdr_t;

  logic clk = 0, rst_n = 0;
  logic esc_clk = 0, esc_valid = 0, esc_lpdt = 0, esc_stop = 0, lane_dir = 1;
  logic ecc_en = 1, rd_start = 0, rp_init = 0;
  logic [7:0] esc_data = 0;
  logic [3:0] esc_trig = 0, rd_idx = 0;
  logic [7:0] rd_byte;
  logic [4:0] pay_cnt;
  logic hdr_done, trg_pulse, trg_te, trg_ack;
  logic [1:0] hdr_vc;
  logic [5:0] hdr_dtype;
  logic [15:0] hdr_word;
  logic [3:0] trg_code, err_status;

  int checks = 0, errors = 0, hdr_seen = 0, trig_cnt = 0;
  logic [3:0] last_code;
  logic last_te, last_ack;
  hdr_t exp_q [$];

  rp_escape_rx u_dut (
    .clk(clk), .rst_n(rst_n), .esc_clk(esc_clk), .esc_data(esc_data),
    .esc_valid(esc_valid), .esc_lpdt(esc_lpdt), .esc_trig(esc_trig),
    .esc_stop(esc_stop), .lane_dir(lane_dir), .ecc_en(ecc_en),
    .rd_start(rd_start), .rp_init(rp_init), .rd_idx(rd_idx),
    .rd_byte(rd_byte), .pay_cnt(pay_cnt), .hdr_done(hdr_done),
    .hdr_vc(hdr_vc), .hdr_dtype(hdr_dtype), .hdr_word(hdr_word),
    .trg_pulse(trg_pulse), .trg_code(trg_code), .trg_te(trg_te),
    .trg_ack(trg_ack), .err_status(err_status));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on each header completion, trigger log
  always @(negedge clk) begin
    if (rst_n && hdr_done) begin
      hdr_seen++;
      if (exp_q.size() == 0) check(1'b0, "R1/R2 unexpected header", 32'(hdr_word), 0);
      else begin
        hdr_t e;
        e = exp_q.pop_front();
        check({hdr_vc, hdr_dtype, hdr_word} == e, "R3 header fields",
              32'({hdr_vc, hdr_dtype, hdr_word}), 32'(e));
      end
    end
    if (rst_n && trg_pulse) begin
      trig_cnt++;
      last_code = trg_code; last_te = trg_te; last_ack = trg_ack;
    end
  end

  function automatic logic [31:0] mk_hdr(input logic [1:0] vc, input logic [5:0] dt, input logic [15:0] w);
    logic [23:0] d;
    logic [4:0] p;
    d = {w, vc, dt};
    p = 0;
    foreach (CODES[i]) if (d[i]) p ^= CODES[i];
    return {2'b00, (^d) ^ (^p), p, d};
  endfunction

  task automatic esc_byte(input logic [7:0] b, input logic lp);
    @(negedge clk);
    esc_data = b; esc_valid = 1; esc_lpdt = lp;
    repeat (HALF) @(negedge clk);
    esc_clk = 1;
    repeat (HALF) @(negedge clk);
    esc_clk = 0;
  endtask

  task automatic end_tx();
    repeat (3) @(negedge clk);
    esc_valid = 0; esc_lpdt = 0; esc_stop = 1;
    repeat (6) @(negedge clk);
    esc_stop = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [31:0] h);
    for (int k = 0; k < 4; k++) esc_byte(h[8*k +: 8], 1'b1);
  endtask

  task automatic send_pay(input int n, input logic [7:0] base);
    for (int k = 0; k < n; k++) esc_byte(base + 8'(k), 1'b1);
  endtask

  task automatic turnaround(input logic [3:0] exp_err, input string req);
    @(negedge clk); lane_dir = 0;
    repeat (8) @(negedge clk);
    check(err_status == exp_err, req, 32'(err_status), 32'(exp_err));
    lane_dir = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic trigger(input logic [3:0] t);
    @(negedge clk); esc_trig = t;
    repeat (8) @(negedge clk);
    esc_stop = 1; repeat (4) @(negedge clk);
    esc_trig = 0; esc_stop = 0; repeat (6) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hdr_t prev;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(err_status == 0 && pay_cnt == 0 && !trg_pulse && !hdr_done, "R10 reset state",
          {err_status, 3'b0, pay_cnt}, 0);

    // R3 short packet
    exp_q.push_back('{2'd1, 6'h21, 16'h1234});
    send_hdr(mk_hdr(2'd1, 6'h21, 16'h1234)); end_tx();
    check(pay_cnt == 0, "R3 short packet stores no payload", 32'(pay_cnt), 0);

    // R3/R6 long packet, 3 bytes
    exp_q.push_back('{2'd2, 6'h1A, 16'd3});
    send_hdr(mk_hdr(2'd2, 6'h1A, 16'd3)); send_pay(3, 8'hA0); end_tx();
    check(pay_cnt == 3, "R6 payload count", 32'(pay_cnt), 3);
    for (int k = 0; k < 4; k++) begin
      rd_idx = 4'(k); #1;
      check(rd_byte == ((k < 3) ? 8'hA0 + 8'(k) : 8'h00), "R6 payload readout",
            32'(rd_byte), (k < 3) ? 32'(8'hA0 + 8'(k)) : 0);
    end
    turnaround(4'b0000, "R8 clean turnaround");

    // R4 single flipped bit corrected
    exp_q.push_back('{2'd3, 6'h22, 16'hBEEF});
    send_hdr(mk_hdr(2'd3, 6'h22, 16'hBEEF) ^ (32'd1 << 10)); end_tx();
    check(err_status == 0, "R8 status held before turnaround", 32'(err_status), 0);
    turnaround(4'b0001, "R4 corrected flag published");

    // R5 double error: outputs hold, payload skipped
    exp_q.push_back('{2'd3, 6'h22, 16'hBEEF});
    send_hdr(mk_hdr(2'd0, 6'h1A, 16'd2) ^ (32'd1 << 2) ^ (32'd1 << 17));
    send_pay(2, 8'h55); end_tx();
    check(pay_cnt == 3, "R5 uncorrectable keeps payload", 32'(pay_cnt), 3);
    turnaround(4'b0010, "R5 uncorrectable flag");

    // R5 bypass when checking disabled
    ecc_en = 0;
    exp_q.push_back('{2'd0, 6'h21, 16'h1236});
    send_hdr(mk_hdr(2'd0, 6'h21, 16'h1234) ^ (32'd1 << 9)); end_tx();
    turnaround(4'b0000, "R5 bypass raises nothing");
    ecc_en = 1;

    // R6 oversize long packet
    exp_q.push_back('{2'd1, 6'h1C, 16'd20});
    send_hdr(mk_hdr(2'd1, 6'h1C, 16'd20)); send_pay(20, 8'h10); end_tx();
    check(pay_cnt == 16, "R6 truncated to 16", 32'(pay_cnt), 16);
    rd_idx = 4'd15; #1;
    check(rd_byte == 8'h1F, "R6 last kept byte", 32'(rd_byte), 32'h1F);
    turnaround(4'b1000, "R6 oversize flag");

    // R7 stop in the middle of payload
    exp_q.push_back('{2'd2, 6'h1A, 16'd5});
    send_hdr(mk_hdr(2'd2, 6'h1A, 16'd5)); send_pay(2, 8'h77); end_tx();
    check(pay_cnt == 2, "R7 partial payload", 32'(pay_cnt), 2);
    check(err_status == 0, "R8 no early publish", 32'(err_status), 0);
    turnaround(4'b0100, "R7 truncation flag");

    // R9 triggers
    trigger(4'b0010);
    check(trig_cnt == 1 && last_code == 4'b0010 && last_te && !last_ack, "R9 TE trigger",
          {trig_cnt[3:0], last_code, 2'b0, last_te, last_ack}, 32'h122 >> 0);
    trigger(4'b0100);
    check(trig_cnt == 2 && last_code == 4'b0100 && !last_te && last_ack, "R9 ack trigger",
          {trig_cnt[3:0], last_code}, 32'h24);

    // R1 direction low: bytes and triggers ignored
    seen = hdr_seen;
    @(negedge clk); lane_dir = 0; repeat (8) @(negedge clk);
    send_hdr(mk_hdr(2'd1, 6'h21, 16'h0001)); end_tx();
    trigger(4'b0001);
    lane_dir = 1; repeat (8) @(negedge clk);
    check(hdr_seen == seen && trig_cnt == 2, "R1 direction low ignores input",
          {hdr_seen[15:0], trig_cnt[15:0]}, {seen[15:0], 16'd2});

    // R2 valid without low-power-data flag
    for (int k = 0; k < 4; k++) esc_byte(8'h33, 1'b0);
    end_tx();
    check(hdr_seen == seen, "R2 lpdt low ignored", hdr_seen, seen);

    // R10 read start empties buffer
    @(negedge clk); rd_start = 1; @(negedge clk); rd_start = 0;
    rd_idx = 0; #1;
    check(pay_cnt == 0 && rd_byte == 0, "R10 rd_start clears", {pay_cnt, rd_byte}, 0);

    // R10 init clears published status
    exp_q.push_back('{2'd0, 6'h1A, 16'd4});
    send_hdr(mk_hdr(2'd0, 6'h1A, 16'd4)); send_pay(1, 8'h01); end_tx();
    @(negedge clk); lane_dir = 0; repeat (8) @(negedge clk);
    check(err_status == 4'b0100, "R8 published on falling direction", 32'(err_status), 4);
    rp_init = 1; @(negedge clk); rp_init = 0; @(negedge clk);
    check(err_status == 0 && pay_cnt == 0, "R10 init clears", {err_status, pay_cnt}, 0);
    lane_dir = 1; repeat (8) @(negedge clk);

    check(exp_q.size() == 0, "R3 all headers seen", exp_q.size(), 0);
    prev = '0;
    $display("CHECKS %0d ERRORS %0d", checks, errors + 0 * int'(prev.vc));
    $finish;
  end
endmodule